// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block is a synthesizable model of a 2-kilobit serial EEPROM that a host drives over a chip-select, serial-clock and data-in line, and that answers on a tri-state data-out line given here as a value plus an output enable. A static width input chooses whether the 2048 bits are seen as 128 words of 16 bits or as 256 bytes. The block runs on a system clock. All three serial inputs and the width input are synchronized into that domain, and every serial-clock and chip-select edge is detected there.

Each command begins with a start bit, followed by a two-bit opcode, an address field and, for the two write commands, a data field. Seven commands are supported: read with automatic continuation to the next word, write of a single word, erase of a single word, erase of the whole array, write of the whole array, and a pair that sets or clears a write-enable latch. A programming command takes effect when chip select falls after its last bit. A counter then holds the block busy for a fixed number of system clocks. A host that raises chip select again sees busy or ready on data-out.

Top module: `tw_eeprom`

## Requirements
- R1: While chip select is high and no command is open, serial-clock rising edges with data-in low are ignored. The first rising edge with data-in high is the start bit, provided no programming cycle is running.
- R2: The two bits after the start bit form the opcode, sent first bit first: 10 reads, 01 writes a word, 11 erases a word. Opcode 00 takes its meaning from the next two bits: 11 sets the write-enable latch, 00 clears it, 10 erases the whole array, 01 writes the whole array.
- R3: With wide_i high, the address field is 7 bits (a word index) and data is 16 bits. With wide_i low, the address field is 9 bits. Its first bit is ignored and the other 8 bits form a byte index b, which maps to bits [15:8] of word b>>1 when b[0] is 1 and to bits [7:0] when b[0] is 0. Data is then 8 bits. All fields are sent most significant bit first.
- R4: After reset the write-enable latch is clear. While it is clear, the four programming commands change no memory and start no programming cycle. Read works whether the latch is set or clear.
- R5: After the last address bit of a read, sdo_oe_o goes high and data-out shows a single 0. Each following serial-clock rising edge presents the next bit of the addressed word or byte, most significant first.
- R6: While chip select stays high, a read continues with the next word or byte. After the last index it continues at index 0.
- R7: Erase sets every bit of the addressed word or byte to 1. Erase-all sets the whole array to 1. Write-all stores the given data in every word (in byte mode, in every byte).
- R8: A command is carried out only on the chip-select falling edge after all of its bits have arrived. A command cut short leaves memory and status unchanged.
- R9: While chip select is low, sdo_oe_o is low and the command decoder returns to waiting for a start bit.
- R10: A programming command makes the block busy for PROG_CYCLES system clocks, whatever chip select does in that time. While chip select is high and no command is open, data-out shows 0 when busy and 1 when ready.
- R11: The busy/ready status stays visible across later chip-select high periods. It is removed when a start bit is received and chip select then falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| wide_i | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| sdo_o | output | 1 | Serial data or busy/ready status |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
The assertions assume that the serial inputs change slowly compared with the system clock, so that each serial-clock level lasts several system cycles after synchronization. They also assume that wide_i changes only while chip select is low. The bench holds each serial-clock phase for four system clocks and sets data-in well before each rising edge. It changes the width input only between commands, and it starts no command until polling has shown the block ready.

// File: rtl/tw_eeprom_pkg.sv
`timescale 1ns/1ps
package tw_eeprom_pkg;

   typedef enum logic [1:0] {
      OP_EXT   = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_ERASE = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      EXT_LOCK  = 2'b00,
      EXT_FILL  = 2'b01,
      EXT_CLEAR = 2'b10,
      EXT_OPEN  = 2'b11
   } ext_e;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_WRITE,
      ACT_ERASE,
      ACT_CLEAR_ALL,
      ACT_FILL_ALL,
      ACT_OPEN,
      ACT_LOCK
   } act_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_DATA,
      ST_READ,
      ST_HOLD
   } cmd_state_e;

endpackage

// File: rtl/tw_sync.sv
`timescale 1ns/1ps
module tw_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("tw_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_timer.sv
`timescale 1ns/1ps
module tw_timer #(
   parameter int CYCLES = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [CW-1:0] cnt;

   if (CYCLES < 1) begin : g_bad_cycles
      $error("tw_timer needs a positive cycle count");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - ONE;
   end

   assign busy = (cnt != '0);

   // R10: a programming cycle is busy in the cycle after it is launched
   a_r10_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   // R10: busy never ends right after a launch
   a_r10_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !$past(start));
endmodule

// File: rtl/tw_array.sv
`timescale 1ns/1ps
module tw_array #(
   parameter int WORDS  = 128,
   parameter int WORD_W = 16
) (
   input  logic                      clk,
   input  logic                      wr_en,
   input  logic                      wr_all,
   input  logic [$clog2(WORDS)-1:0]  wr_addr,
   input  logic [1:0]                wr_mask,
   input  logic [WORD_W-1:0]         wr_data,
   input  logic [$clog2(WORDS)-1:0]  rd_addr,
   output logic [WORD_W-1:0]         rd_data
);
   localparam int AW = $clog2(WORDS);
   localparam int HW = WORD_W / 2;

   logic [WORD_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int w = 0; w < WORDS; w++) begin
            if (wr_all || (wr_addr == AW'(w))) begin
               for (int l = 0; l < 2; l++) begin
                  if (wr_mask[l]) mem[w][l*HW +: HW] <= wr_data[l*HW +: HW];
               end
            end
         end
      end
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tw_cmd.sv
`timescale 1ns/1ps
module tw_cmd
   import tw_eeprom_pkg::*;
#(
   parameter int AW     = 7,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sclk_s,
   input  logic              di_s,
   input  logic              wide_s,
   input  logic              busy,
   input  logic [WORD_W-1:0] rd_word,
   output logic [AW-1:0]     rd_word_addr,
   output logic              exec_o,
   output act_e              act_o,
   output logic [AW:0]       addr_o,
   output logic [WORD_W-1:0] data_o,
   output logic              clr_status_o,
   output logic              idle_o,
   output logic              rd_mode_o,
   output logic              sdo_bit_o
);
   localparam int FW  = AW + 2;
   localparam int HW  = WORD_W / 2;
   localparam int CW  = $clog2(FW + WORD_W + 3);
   localparam int OBW = $clog2(WORD_W);
   localparam logic [CW-1:0]  CNT_ONE  = CW'(1);
   localparam logic [CW-1:0]  CNT_TWO  = CW'(2);
   localparam logic [AW:0]    PTR_ONE  = (AW+1)'(1);
   localparam logic [AW-1:0]  ADDR_ONE = AW'(1);

   cmd_state_e        state;
   logic              cs_q, sclk_q;
   logic [CW-1:0]     cnt;
   logic [1:0]        op;
   logic [FW-1:0]     field;
   logic [WORD_W-1:0] data_sr;
   act_e              act;
   logic              armed, clr_pend;
   logic [AW:0]       rd_ptr;
   logic [OBW-1:0]    ob;
   logic              sdo_q;

   logic              rise, cs_fall;
   logic [FW-1:0]     field_nx;
   logic [CW-1:0]     hdr_last, data_last;
   logic [OBW-1:0]    ob_top;
   logic [1:0]        ext_code;
   logic [WORD_W-1:0] half_word;
   logic [AW:0]       ptr_inc;

   assign rise      = cs_s & sclk_s & ~sclk_q;
   assign cs_fall   = cs_q & ~cs_s;
   assign field_nx  = {field[FW-2:0], di_s};
   assign hdr_last  = wide_s ? CW'(AW + 1) : CW'(FW + 1);
   assign data_last = wide_s ? CW'(WORD_W - 1) : CW'(HW - 1);
   assign ob_top    = wide_s ? OBW'(WORD_W - 1) : OBW'(HW - 1);
   assign ext_code  = wide_s ? field_nx[AW-1:AW-2] : field_nx[FW-1:FW-2];
   assign ptr_inc   = wide_s ? {1'b0, rd_ptr[AW-1:0] + ADDR_ONE} : rd_ptr + PTR_ONE;
   assign half_word = (!wide_s && rd_ptr[0]) ? (rd_word >> HW) : rd_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cs_q     <= 1'b0;
         sclk_q   <= 1'b0;
         cnt      <= '0;
         op       <= '0;
         field    <= '0;
         data_sr  <= '0;
         act      <= ACT_NONE;
         armed    <= 1'b0;
         clr_pend <= 1'b0;
         rd_ptr   <= '0;
         ob       <= '0;
         sdo_q    <= 1'b0;
      end else begin
         cs_q   <= cs_s;
         sclk_q <= sclk_s;
         if (!cs_s) begin
            state    <= ST_IDLE;
            armed    <= 1'b0;
            clr_pend <= 1'b0;
            cnt      <= '0;
         end else if (rise) begin
            unique case (state)
               ST_IDLE: begin
                  if (di_s && !busy) begin
                     state    <= ST_HDR;
                     cnt      <= '0;
                     clr_pend <= 1'b1;
                  end
               end
               ST_HDR: begin
                  if (cnt < CNT_TWO) op <= {op[0], di_s};
                  else               field <= field_nx;
                  cnt <= cnt + CNT_ONE;
                  if (cnt == hdr_last) begin
                     cnt <= '0;
                     unique case (op_e'(op))
                        OP_READ: begin
                           state  <= ST_READ;
                           rd_ptr <= wide_s ? {1'b0, field_nx[AW-1:0]} : field_nx[AW:0];
                           ob     <= ob_top;
                           sdo_q  <= 1'b0;
                        end
                        OP_WRITE: begin
                           act   <= ACT_WRITE;
                           state <= ST_DATA;
                        end
                        OP_ERASE: begin
                           act   <= ACT_ERASE;
                           armed <= 1'b1;
                           state <= ST_HOLD;
                        end
                        OP_EXT: begin
                           unique case (ext_e'(ext_code))
                              EXT_FILL: begin
                                 act   <= ACT_FILL_ALL;
                                 state <= ST_DATA;
                              end
                              EXT_CLEAR: begin
                                 act   <= ACT_CLEAR_ALL;
                                 armed <= 1'b1;
                                 state <= ST_HOLD;
                              end
                              EXT_OPEN: begin
                                 act   <= ACT_OPEN;
                                 armed <= 1'b1;
                                 state <= ST_HOLD;
                              end
                              EXT_LOCK: begin
                                 act   <= ACT_LOCK;
                                 armed <= 1'b1;
                                 state <= ST_HOLD;
                              end
                           endcase
                        end
                     endcase
                  end
               end
               ST_DATA: begin
                  data_sr <= {data_sr[WORD_W-2:0], di_s};
                  cnt     <= cnt + CNT_ONE;
                  if (cnt == data_last) begin
                     armed <= 1'b1;
                     state <= ST_HOLD;
                  end
               end
               ST_READ: begin
                  sdo_q <= half_word[ob];
                  if (ob == '0) begin
                     ob     <= ob_top;
                     rd_ptr <= ptr_inc;
                  end else begin
                     ob <= ob - OBW'(1);
                  end
               end
               ST_HOLD: begin
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign exec_o       = cs_fall & armed;
   assign clr_status_o = cs_fall & clr_pend;
   assign act_o        = act;
   assign addr_o       = field[AW:0];
   assign data_o       = data_sr;
   assign idle_o       = (state == ST_IDLE);
   assign rd_mode_o    = (state == ST_READ);
   assign sdo_bit_o    = sdo_q;
   assign rd_word_addr = wide_s ? rd_ptr[AW-1:0] : rd_ptr[AW:1];

   // R9: a deselect always returns the decoder to waiting, with nothing pending
   a_r9_reset_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> (state == ST_IDLE) && !armed);

   // R1: with data-in low, an idle decoder stays idle
   a_r1_no_start_on_low_di: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) && !di_s |=> (state == ST_IDLE));
endmodule

// File: rtl/tw_eeprom.sv
`timescale 1ns/1ps
module tw_eeprom
   import tw_eeprom_pkg::*;
#(
   parameter int WORDS       = 128,
   parameter int WORD_W      = 16,
   parameter int PROG_CYCLES = 4000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sclk_i,
   input  logic sdi_i,
   input  logic wide_i,
   output logic sdo_o,
   output logic sdo_oe_o
);
   localparam int AW = $clog2(WORDS);
   localparam int HW = WORD_W / 2;

   if ((WORDS < 4) || ((1 << AW) != WORDS)) begin : g_bad_words
      $error("WORDS must be a power of two, at least 4");
   end
   if ((WORD_W < 4) || (WORD_W % 2 != 0)) begin : g_bad_width
      $error("WORD_W must be even and at least 4");
   end

   logic [3:0] raw_in, sync_out;
   logic       cs_s, sclk_s, di_s, wide_s;

   assign raw_in = {wide_i, sdi_i, sclk_i, cs_i};

   tw_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   assign {wide_s, di_s, sclk_s, cs_s} = sync_out;

   logic              busy, exec, clr_status, idle, rd_mode, sdo_bit;
   act_e              act;
   logic [AW:0]       cmd_addr;
   logic [WORD_W-1:0] cmd_data, rd_word;
   logic [AW-1:0]     rd_addr;

   tw_cmd #(.AW(AW), .WORD_W(WORD_W)) u_cmd (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_s         (cs_s),
      .sclk_s       (sclk_s),
      .di_s         (di_s),
      .wide_s       (wide_s),
      .busy         (busy),
      .rd_word      (rd_word),
      .rd_word_addr (rd_addr),
      .exec_o       (exec),
      .act_o        (act),
      .addr_o       (cmd_addr),
      .data_o       (cmd_data),
      .clr_status_o (clr_status),
      .idle_o       (idle),
      .rd_mode_o    (rd_mode),
      .sdo_bit_o    (sdo_bit)
   );

   logic wel, status_show;
   logic is_prog, prog_go, fill_all, erase_op;
   logic [AW-1:0]     wr_addr;
   logic [1:0]        wr_mask;
   logic [WORD_W-1:0] wr_data;

   assign is_prog  = (act == ACT_WRITE) || (act == ACT_ERASE) ||
                     (act == ACT_CLEAR_ALL) || (act == ACT_FILL_ALL);
   assign prog_go  = exec && is_prog && wel;
   assign fill_all = (act == ACT_CLEAR_ALL) || (act == ACT_FILL_ALL);
   assign erase_op = (act == ACT_ERASE) || (act == ACT_CLEAR_ALL);
   assign wr_addr  = wide_s ? cmd_addr[AW-1:0] : cmd_addr[AW:1];
   assign wr_mask  = (wide_s || fill_all) ? 2'b11 : (cmd_addr[0] ? 2'b10 : 2'b01);
   assign wr_data  = erase_op ? '1 : (wide_s ? cmd_data : {2{cmd_data[HW-1:0]}});

   tw_array #(.WORDS(WORDS), .WORD_W(WORD_W)) u_array (
      .clk     (clk),
      .wr_en   (prog_go),
      .wr_all  (fill_all),
      .wr_addr (wr_addr),
      .wr_mask (wr_mask),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_word)
   );

   tw_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (prog_go),
      .busy  (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel         <= 1'b0;
         status_show <= 1'b0;
      end else begin
         if (exec && (act == ACT_OPEN)) wel <= 1'b1;
         if (exec && (act == ACT_LOCK)) wel <= 1'b0;
         if (prog_go)         status_show <= 1'b1;
         else if (clr_status) status_show <= 1'b0;
      end
   end

   assign sdo_o    = rd_mode ? sdo_bit : ~busy;
   assign sdo_oe_o = cs_s & (rd_mode | (status_show & idle));

   // R4: a programming cycle is only ever launched with the latch set
   a_r4_busy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel));
endmodule

// File: tb/tw_eeprom_test.sv
`timescale 1ns/1ps
module tw_eeprom_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sclk = 1'b0, di = 1'b0, wide = 1'b1;
   logic sdo, sdo_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [15:0] model [128];

   always #10 clk = ~clk;

   tw_eeprom #(.PROG_CYCLES(40)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_i     (cs),
      .sclk_i   (sclk),
      .sdi_i    (di),
      .wide_i   (wide),
      .sdo_o    (sdo),
      .sdo_oe_o (sdo_oe)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bitclk(input logic b);
      di = b;
      wait_n(4);
      sclk = 1'b1;
      wait_n(4);
      sclk = 1'b0;
   endtask

   task automatic send(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) bitclk(v[i]);
   endtask

   task automatic sel();
      cs = 1'b1;
      wait_n(4);
   endtask

   task automatic desel();
      cs = 1'b0; di = 1'b0; sclk = 1'b0;
      wait_n(6);
   endtask

   task automatic hdr(input logic [1:0] op, input logic [8:0] field);
      bitclk(1'b1);
      send({30'b0, op}, 2);
      send({23'b0, field}, wide ? 7 : 9);
   endtask

   function automatic logic [8:0] extf(input logic [1:0] code);
      return wide ? {2'b00, code, 5'b0} : {code, 7'b0};
   endfunction

   function automatic logic [7:0] byte_of(input int b);
      return b[0] ? model[(b >> 1) & 127][15:8] : model[(b >> 1) & 127][7:0];
   endfunction

   task automatic short_cmd(input logic [1:0] op, input logic [8:0] field);
      sel();
      hdr(op, field);
      desel();
   endtask

   task automatic wait_ready();
      sel();
      check(sdo_oe === 1'b1 && sdo === 1'b0, "R10 busy shown", {sdo_oe, sdo}, 2'b10);
      for (int k = 0; k < 200 && sdo !== 1'b1; k++) wait_n(1);
      check(sdo_oe === 1'b1 && sdo === 1'b1, "R10 ready shown", {sdo_oe, sdo}, 2'b11);
      desel();
      sel();
      check(sdo_oe === 1'b1 && sdo === 1'b1, "R11 status kept", {sdo_oe, sdo}, 2'b11);
      bitclk(1'b1);
      desel();
      sel();
      check(sdo_oe === 1'b0, "R11 status cleared", {31'b0, sdo_oe}, 0);
      desel();
   endtask

   task automatic read16(input int start, input int n, input string req);
      logic [15:0] got;
      sel();
      repeat (3) bitclk(1'b0);
      check(sdo_oe === 1'b0, "R1 low clocks ignored", {31'b0, sdo_oe}, 0);
      hdr(2'b10, 9'(start & 127));
      check(sdo_oe === 1'b1 && sdo === 1'b0, "R5 dummy zero", {sdo_oe, sdo}, 2'b10);
      for (int w = 0; w < n; w++) begin
         got = '0;
         for (int b = 0; b < 16; b++) begin
            bitclk(1'b0);
            got = {got[14:0], sdo};
         end
         check(got === model[(start + w) % 128], req, {16'b0, got}, {16'b0, model[(start + w) % 128]});
      end
      desel();
   endtask

   task automatic read8(input int start, input int n, input string req);
      logic [7:0] got;
      sel();
      hdr(2'b10, {1'b0, 8'(start)});
      check(sdo_oe === 1'b1 && sdo === 1'b0, "R5 dummy zero byte", {sdo_oe, sdo}, 2'b10);
      for (int w = 0; w < n; w++) begin
         got = '0;
         for (int b = 0; b < 8; b++) begin
            bitclk(1'b0);
            got = {got[6:0], sdo};
         end
         check(got === byte_of((start + w) % 256), req, {24'b0, got}, {24'b0, byte_of((start + w) % 256)});
      end
      desel();
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired got running expected finished");
         finish_up();
      end
   end

   initial begin
      wait_n(5);
      rst_n = 1'b1;
      wait_n(3);
      // R9: deselected after reset
      check(sdo_oe === 1'b0, "R9 reset hi-z", {31'b0, sdo_oe}, 0);
      sel();
      check(sdo_oe === 1'b0, "R10 no status after reset", {31'b0, sdo_oe}, 0);
      desel();

      // R2: extended group, enable then erase-all
      short_cmd(2'b00, extf(2'b11));
      short_cmd(2'b00, extf(2'b10));
      wait_ready();
      for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;

      // R4: lock, then a write must do nothing
      short_cmd(2'b00, extf(2'b00));
      sel(); hdr(2'b01, 9'd5); send(32'h1234, 16); desel();
      sel();
      check(sdo_oe === 1'b0, "R4 locked write no status", {31'b0, sdo_oe}, 0);
      desel();
      read16(5, 1, "R4 locked write no change");

      // R2 R3 R7: word writes sweep
      short_cmd(2'b00, extf(2'b11));
      for (int i = 0; i < 128; i++) begin
         logic [15:0] p;
         p = (16'(i) * 16'h0123) ^ 16'h5A3C;
         sel(); hdr(2'b01, 9'(i)); send({16'b0, p}, 16); desel();
         wait_ready();
         model[i] = p;
      end
      read16(0, 128, "R2 R5 word sweep");
      read16(120, 12, "R6 word wrap");

      // R3: byte view of the same array, wrap at 256
      wide = 1'b0;
      wait_n(4);
      read8(0, 258, "R3 R6 byte sweep");

      // R3: byte writes, leading field bit ignored
      sel(); hdr(2'b01, {1'b1, 8'd7}); send(32'h9E, 8); desel();
      wait_ready();
      model[3][15:8] = 8'h9E;
      sel(); hdr(2'b01, {1'b0, 8'd200}); send(32'h3C, 8); desel();
      wait_ready();
      model[100][7:0] = 8'h3C;
      // R7: byte erase
      short_cmd(2'b11, {1'b0, 8'd10});
      wait_ready();
      model[5][7:0] = 8'hFF;

      wide = 1'b1;
      wait_n(4);
      // R7: word erase
      short_cmd(2'b11, 9'd9);
      wait_ready();
      model[9] = 16'hFFFF;
      read16(3, 8, "R3 R7 byte write and erase");
      read16(100, 1, "R3 byte write low half");

      // R8: write cut short
      sel(); hdr(2'b01, 9'd20); send(32'h3FF, 10); desel();
      sel();
      check(sdo_oe === 1'b0, "R8 short command no status", {31'b0, sdo_oe}, 0);
      desel();
      read16(20, 1, "R8 short command no change");

      // R9: read cut by deselect
      sel(); hdr(2'b10, 9'd40); send(32'h0, 5);
      desel();
      check(sdo_oe === 1'b0, "R9 deselect mid read", {31'b0, sdo_oe}, 0);
      read16(40, 1, "R9 new command after cut");

      // R7: word write-all
      sel(); hdr(2'b00, extf(2'b01)); send(32'hC33C, 16); desel();
      wait_ready();
      for (int i = 0; i < 128; i++) model[i] = 16'hC33C;
      read16(126, 4, "R7 write-all words");

      // R7: byte write-all
      wide = 1'b0;
      wait_n(4);
      sel(); hdr(2'b00, extf(2'b01)); send(32'h6B, 8); desel();
      wait_ready();
      for (int i = 0; i < 128; i++) model[i] = 16'h6B6B;
      read8(0, 6, "R7 write-all bytes");
      read8(254, 4, "R7 R6 byte wrap");

      // R4: lock, erase-all ignored, read still works
      short_cmd(2'b00, extf(2'b00));
      short_cmd(2'b00, extf(2'b10));
      sel();
      check(sdo_oe === 1'b0, "R4 locked erase-all no status", {31'b0, sdo_oe}, 0);
      desel();
      read8(17, 3, "R4 read while locked");

      done = 1'b1;
      finish_up();
   end
endmodule